// File: doc/BRIEF.md
# 5x5 Sliding Window Register Matrix

This block turns a raster stream of grayscale pixels into a square 5x5 neighbourhood that moves one pixel for each accepted input pixel. Four line stores, each as deep as the image is wide, hold the earlier rows. The newest row comes straight from the input. Each accepted pixel shifts every line store and every window register by one position, and the whole window is then presented in parallel on one wide output. Nothing is copied into a separate window buffer.

The block runs on the internal clock, which is four times the pixel rate. The 24 pixels around the centre are split into six lanes of four. Over the four internal cycles that follow each accepted pixel, a select index steps from 0 to 3 and each lane carries one of its four pixels per cycle. The index is an output, so that the six downstream pipelines can align to it. The centre pixel has an output of its own.

Top module: `win5_regmatrix`

## Requirements
- R1: After reset, `win_vld_o` and `grp_vld_o` are low and `grp_phase_o` is 3.
- R2: The window changes only in the cycle after a cycle with `pix_valid_i` high. At that point, element index r*5+c (bits `[(r*5+c)*PIX_W +: PIX_W]`) holds the pixel at image row y-4+r, column x-4+c, where (y,x) is the position of the pixel just accepted. Row r=0 is the top row and column c=0 is the left column.
- R3: The window-valid flag is updated with each accepted pixel. It is high exactly when the accepted pixel lies at frame row 4 or below and at column 4 or beyond. It is therefore low for the first four columns of every row.
- R4: An accepted pixel with `sof_i` high is placed at row 0, column 0 of a new frame. `sof_i` has no effect while `pix_valid_i` is low.
- R5: Columns count from 0 to IMG_W-1. The pixel after column IMG_W-1 starts column 0 of the next row.
- R6: `centre_o` equals window element (2,2).
- R7: `grp_phase_o` is 0 in the cycle after an accepted pixel. It then rises by one per cycle up to 3 and stays at 3 until the next accepted pixel.
- R8: Number the 24 neighbours 0..23 in raster order, top row first, skipping the centre. Lane g (bits `[g*PIX_W +: PIX_W]` of `grp_o`) at phase p carries neighbour 6*p+g.
- R9: `grp_vld_o` is high for the four cycles after an accepted pixel whose window is valid, and low otherwise.
- R10: Accepted pixels must be at least four cycles apart. Longer gaps are allowed and leave all outputs unchanged, apart from the phase reaching 3 and `grp_vld_o` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, four times the pixel rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Input pixel present this cycle |
| sof_i | input | 1 | Marks the first pixel of a frame |
| pix_i | input | PIX_W | Grayscale pixel |
| win_o | output | 25*PIX_W | Full 5x5 window, element r*5+c |
| win_vld_o | output | 1 | Window is complete |
| centre_o | output | PIX_W | Centre pixel of the window |
| grp_o | output | 6*PIX_W | Six lane outputs, one neighbour each per cycle |
| grp_phase_o | output | 2 | Lane select index 0..3 |
| grp_vld_o | output | 1 | Lane outputs carry a valid window |

## Verification
The bench builds the block with IMG_W=7, a width that is not a power of two and only two columns wider than the window. With this width, line wrap happens every few pixels and row-edge invalidation covers most of each row. Frames of nine rows and more reach the state in which the row counter saturates, and a new frame start in the middle of a row tests the restart. Pixel spacings of four, five and seven cycles exercise both a continuous lane stream and the phase holding at 3.

// File: rtl/win5_pkg.sv
package win5_pkg;
  localparam int WIN_N   = 5;
  localparam int WIN_CNT = WIN_N * WIN_N;
  localparam int NBR_CNT = WIN_CNT - 1;
  localparam int LANES   = 6;
  localparam int BEATS   = NBR_CNT / LANES;
  localparam int CTR_IDX = WIN_CNT / 2;

  // raster position (0..24) of neighbour n (0..23), centre skipped
  function automatic int nbr_to_pos(input int n);
    return (n < CTR_IDX) ? n : n + 1;
  endfunction

  // neighbour carried by a lane in a given beat
  function automatic int lane_nbr(input int lane, input int beat);
    return beat * LANES + lane;
  endfunction
endpackage

// File: rtl/win5_linestore.sv
module win5_linestore #(
  parameter int IMG_W = 64,
  parameter int PIX_W = 8,
  parameter int NLB   = 4,
  localparam int CW   = $clog2(IMG_W)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [CW-1:0]        idx,
  input  logic [PIX_W-1:0]     din,
  output logic [NLB*PIX_W-1:0] taps_o
);
  logic [PIX_W-1:0] chain [0:NLB];
  assign chain[0] = din;

  for (genvar k = 0; k < NLB; k++) begin : g_lb
    logic [PIX_W-1:0] mem [0:IMG_W-1];
    assign chain[k+1] = mem[idx];
    assign taps_o[k*PIX_W +: PIX_W] = chain[k+1];
    always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= chain[k];
    end
  end
endmodule

// File: rtl/win5_shifter.sv
module win5_shifter #(
  parameter int PIX_W = 8,
  localparam int N    = win5_pkg::WIN_N
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift,
  input  logic [N*PIX_W-1:0]       col_in,
  output logic [N*N*PIX_W-1:0]     win_o
);
  logic [PIX_W-1:0] w [0:N*N-1];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w[r*N+c] <= '0;
        else if (shift) begin
          if (c == N-1) w[r*N+c] <= col_in[r*PIX_W +: PIX_W];
          else          w[r*N+c] <= w[r*N+c+1];
        end
      end
      assign win_o[(r*N+c)*PIX_W +: PIX_W] = w[r*N+c];
    end
  end
endmodule

// File: rtl/win5_lanemux.sv
module win5_lanemux #(
  parameter int PIX_W = 8,
  localparam int WC   = win5_pkg::WIN_CNT,
  localparam int NL   = win5_pkg::LANES
) (
  input  logic [WC*PIX_W-1:0] win,
  input  logic [1:0]          sel,
  output logic [NL*PIX_W-1:0] lanes_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_comb begin
      lanes_o[g*PIX_W +: PIX_W] = '0;
      for (int b = 0; b < win5_pkg::BEATS; b++) begin
        if (int'(sel) == b)
          lanes_o[g*PIX_W +: PIX_W] =
            win[win5_pkg::nbr_to_pos(win5_pkg::lane_nbr(g, b))*PIX_W +: PIX_W];
      end
    end
  end
endmodule

// File: rtl/win5_regmatrix.sv
module win5_regmatrix #(
  parameter int IMG_W = 64,
  parameter int PIX_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pix_valid_i,
  input  logic                                  sof_i,
  input  logic [PIX_W-1:0]                      pix_i,
  output logic [win5_pkg::WIN_CNT*PIX_W-1:0]    win_o,
  output logic                                  win_vld_o,
  output logic [PIX_W-1:0]                      centre_o,
  output logic [win5_pkg::LANES*PIX_W-1:0]      grp_o,
  output logic [1:0]                            grp_phase_o,
  output logic                                  grp_vld_o
);
  localparam int N    = win5_pkg::WIN_N;
  localparam int NLB  = N - 1;
  localparam int CW   = $clog2(IMG_W);
  localparam int RW   = $clog2(NLB + 1);

  logic          accept;
  logic [CW-1:0] col_cnt, cur_col;
  logic [RW-1:0] row_cnt, cur_row;
  logic          row_end;
  logic [1:0]    phase;
  logic          burst;
  logic          wvld;
  logic [NLB*PIX_W-1:0] taps;
  logic [N*PIX_W-1:0]   col_in;

  assign accept  = pix_valid_i;
  assign cur_col = (sof_i) ? '0 : col_cnt;
  assign cur_row = (sof_i) ? '0 : row_cnt;
  assign row_end = (cur_col == CW'(IMG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_cnt <= '0;
      row_cnt <= '0;
      wvld    <= 1'b0;
    end else if (accept) begin
      col_cnt <= row_end ? '0 : cur_col + 1'b1;
      if (row_end && cur_row != RW'(NLB)) row_cnt <= cur_row + 1'b1;
      else                                row_cnt <= cur_row;
      wvld    <= (cur_row == RW'(NLB)) && (cur_col >= CW'(NLB));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 2'd3;
      burst <= 1'b0;
    end else if (accept) begin
      phase <= 2'd0;
      burst <= 1'b1;
    end else if (burst) begin
      if (phase == 2'd3) burst <= 1'b0;
      else               phase <= phase + 2'd1;
    end
  end

  win5_linestore #(.IMG_W(IMG_W), .PIX_W(PIX_W), .NLB(NLB)) lines_i (
    .clk(clk), .wr_en(accept), .idx(cur_col), .din(pix_i), .taps_o(taps)
  );

  // bottom row is the live input, upper rows come from older line stores
  for (genvar r = 0; r < N; r++) begin : g_col
    if (r == N-1) begin : g_live
      assign col_in[r*PIX_W +: PIX_W] = pix_i;
    end else begin : g_store
      assign col_in[r*PIX_W +: PIX_W] = taps[(NLB-1-r)*PIX_W +: PIX_W];
    end
  end

  win5_shifter #(.PIX_W(PIX_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift(accept), .col_in(col_in), .win_o(win_o)
  );

  win5_lanemux #(.PIX_W(PIX_W)) mux_i (
    .win(win_o), .sel(phase), .lanes_o(grp_o)
  );

  assign win_vld_o   = wvld;
  assign centre_o    = win_o[win5_pkg::CTR_IDX*PIX_W +: PIX_W];
  assign grp_phase_o = phase;
  assign grp_vld_o   = burst && wvld;
endmodule

// File: rtl/win5_chk.sv
module win5_chk #(
  parameter int PIX_W = 8,
  parameter int CW    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic [CW-1:0]        cur_col,
  input logic [25*PIX_W-1:0]  win_o,
  input logic                 win_vld_o,
  input logic [1:0]           grp_phase_o,
  input logic                 grp_vld_o
);
  // R2
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(win_o));
  // R2
  win_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> win_o[3*PIX_W +: PIX_W] == $past(win_o[4*PIX_W +: PIX_W]));
  // R3
  edge_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_col < CW'(4)) |=> !win_vld_o);
  // R7
  phase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> grp_phase_o == 2'd0);
  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && grp_phase_o != 2'd3) |=> grp_phase_o == $past(grp_phase_o) + 2'd1);
  // R9
  lane_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_vld_o |-> win_vld_o);
  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && grp_phase_o == 2'd3) |=> grp_phase_o == 2'd3 && !grp_vld_o);
endmodule

bind win5_regmatrix win5_chk #(.PIX_W(PIX_W), .CW($clog2(IMG_W))) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .cur_col(cur_col),
  .win_o(win_o), .win_vld_o(win_vld_o), .grp_phase_o(grp_phase_o),
  .grp_vld_o(grp_vld_o)
);

// File: tb/win5_regmatrix_tb_top.sv
module win5_regmatrix_tb_top;
  localparam int W = 7;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0, sof = 1'b0;
  logic [P-1:0] pix = '0;
  logic [25*P-1:0] win;
  logic win_vld, grp_vld;
  logic [P-1:0] centre;
  logic [6*P-1:0] grp;
  logic [1:0] phase;

  always #4 clk = ~clk;

  win5_regmatrix #(.IMG_W(W), .PIX_W(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid), .sof_i(sof), .pix_i(pix),
    .win_o(win), .win_vld_o(win_vld), .centre_o(centre), .grp_o(grp),
    .grp_phase_o(phase), .grp_vld_o(grp_vld)
  );

  int total = 0, bad = 0;
  int img [0:63][0:W-1];
  int mx = 0, my = 0, nx = 0, ny = 0;
  int m_ph = 3, m_act = 0, m_vld = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pos_of(input int n);
    return (n < 12) ? n : n + 1;
  endfunction

  task automatic compare();
    chk("R9 grp_vld", grp_vld, (m_act && m_vld) ? 1 : 0);
    chk("R3 win_vld", win_vld, m_vld);
    chk("R7 phase", phase, m_ph);
    if (m_vld) begin
      for (int r = 0; r < 5; r++)
        for (int c = 0; c < 5; c++)
          chk("R2 window", win[(r*5+c)*P +: P], img[my-4+r][mx-4+c]);
      chk("R6 centre", centre, img[my-2][mx-2]);
      if (m_act)
        for (int g = 0; g < 6; g++) begin
          int q;
          q = pos_of(m_ph*6 + g);
          chk("R8 lane", grp[g*P +: P], img[my-4+q/5][mx-4+q%5]);
        end
    end
  endtask

  task automatic cyc(input bit v, input bit s, input int p);
    @(negedge clk);
    compare();
    pix_valid = v; sof = s; pix = P'(p);
    if (v) begin
      int cx, cy;
      cy = s ? 0 : ny;
      cx = s ? 0 : nx;
      img[cy][cx] = p;
      mx = cx; my = cy;
      m_vld = (cy >= 4 && cx >= 4) ? 1 : 0;
      nx = (cx == W-1) ? 0 : cx + 1;            // R5
      ny = (cx == W-1) ? ((cy < 40) ? cy + 1 : cy) : cy;
      m_ph = 0; m_act = 1;
    end else if (m_act) begin
      if (m_ph == 3) m_act = 0; else m_ph++;
    end
  endtask

  task automatic feed(input int npix, input int gap, input int seed, input bit first_sof);
    for (int i = 0; i < npix; i++) begin
      cyc(1'b1, (first_sof && i == 0), (seed + i*37 + (i/W)*11) & 8'hFF);
      for (int k = 0; k < gap; k++) cyc(1'b0, 1'b0, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 win_vld", win_vld, 0);
    chk("R1 grp_vld", grp_vld, 0);
    chk("R1 phase", phase, 3);
    rst_n = 1'b1;
    // R2 R3 R5 R8: full frame at the tightest spacing
    feed(9*W, 3, 5, 1'b1);
    // R10: slower spacing, phase holds at 3
    feed(2*W, 4, 90, 1'b0);
    feed(W + 3, 6, 17, 1'b0);
    // R4: sof without valid is ignored
    cyc(1'b0, 1'b1, 200);
    cyc(1'b0, 1'b1, 201);
    feed(W, 3, 44, 1'b0);
    // R4: new frame started in the middle of a row
    feed(3, 3, 61, 1'b0);
    feed(8*W, 3, 128, 1'b1);
    feed(W, 5, 7, 1'b0);
    repeat (6) cyc(1'b0, 1'b0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule